// File: doc/BRIEF.md
# Time-Slotted Serial Keyboard Bus Interface

This block sits between a keyboard scanner and a bit-serial system bus on which every transfer is placed at a fixed bit position of a 76-bit word cycle. A cycle-marker pulse from the system controller marks bit time 0 of each word cycle. From that pulse the block runs a one-hot chain of stages, with one stage advancing per clock, which acts as a decoded bit-time counter that stays in step with the controller. The block only drives or samples the shared wire inside bit times 11 to 30.

When the scanner delivers a key code, the block latches it and announces it with a character-ready bit at bit time 20. It repeats that bit in every word cycle until the controller answers with a transmit-key command on the serial command line at bit time 12. In that word cycle the code goes out least significant bit first. Separately, a transmit-static command at bit time 11 makes the block send its two static-switch bits in one of four two-bit slots, chosen by a slot select input. Up to four interfaces can therefore share one wire. A request for both transfers in the same word cycle is illegal. The block reports it and sends only the key code.

Top module: `kbd_slot_if`

## Requirements
- R1: After reset, and until the first cycle marker arrives, `bus_oe_o`, `bus_o`, `sync_err_o` and `coll_err_o` are all 0.
- R2: The clock in which `cm_i` is high is bit time 0. The following clocks are bit times 1, 2, … 75, and bit 0 follows bit 75. The first marker after reset is always accepted.
- R3: `bus_oe_o` is high only in bit times inside 11..30 that one of R5, R7 or R8 assigns to the block, and never at 11 or 12. `bus_o` is 0 whenever `bus_oe_o` is 0.
- R4: A key code on `key_code_i` with `key_valid_i` high is latched only when no character is pending. A key offered while one is pending is ignored, and the pending code is kept.
- R5: While a character is pending, the block drives `bus_o`=1 with `bus_oe_o`=1 at bit time 20 of every word cycle.
- R6: `cmd_i` high at bit time 12 is a transmit-key command. It takes effect only if the ready bit of R5 was driven in an earlier word cycle. Otherwise it is ignored.
- R7: In the word cycle of an accepted transmit-key command, bits 21..28 carry the pending code, bit 0 at bit time 21. The pending state ends after bit time 75 of that cycle.
- R8: `cmd_i` high at bit time 11 requests static transmission in that word cycle. `stat_i[0]` then goes out at slot base b and `stat_i[1]` at b+1. The base b is 13, 15, 17 or 29 for `slot_sel_i` = 0, 1, 2 or 3, and 0 is the default first slot.
- R9: If `cmd_i` is high at both bit 11 and bit 12 of one word cycle, `coll_err_o` is high for exactly the clock of bit time 13. The static transfer of that cycle is dropped, while the key transfer proceeds under R6.
- R10: A cycle marker at any bit time other than 0 is ignored by the bit-time chain, and `sync_err_o` is high for the single following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one bit time per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cm_i | input | 1 | Cycle marker, high during bit time 0 |
| cmd_i | input | 1 | Serial command line from the controller |
| key_valid_i | input | 1 | Scanner offers a key code this clock |
| key_code_i | input | CODE_W | Key code from the scanner |
| stat_i | input | 2 | Static switch status bits |
| slot_sel_i | input | 2 | Static slot choice for this interface |
| bus_o | output | 1 | Serial data toward the shared bus |
| bus_oe_o | output | 1 | Output enable for `bus_o` |
| sync_err_o | output | 1 | One-clock pulse after a stray cycle marker |
| coll_err_o | output | 1 | One-clock pulse on a static/key request collision |

## Verification
A static request at bit 11 and a transmit-key command at bit 12 can land in the same word cycle, and that is the overlap that needs care. The bench provokes it in directed cycles, both with a ready character pending and with none, and again whenever random command bits coincide. It judges the overlap at the ports: there is a one-clock error pulse during bit 13, the selected static slot stays silent, and the key code still appears in bits 21..28 when the handshake allowed it.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    // Word-cycle geometry and fixed bit-time positions.
    localparam int unsigned WORD_BITS  = 76;
    localparam int unsigned WIN_FIRST  = 11;
    localparam int unsigned WIN_LAST   = 30;
    localparam int unsigned T_STAT_CMD = 11;
    localparam int unsigned T_KEY_CMD  = 12;
    localparam int unsigned T_READY    = 20;
    localparam int unsigned T_CODE0    = 21;

    // Static status slots.
    localparam int unsigned STAT_SLOTS = 4;
    localparam int unsigned STAT_W     = 2;
    localparam int unsigned SEL_W      = $clog2(STAT_SLOTS);

    typedef logic [SEL_W-1:0] slot_sel_t;

    // First bit time of each static slot; slots avoid bits 12 and 20 and the code window.
    function automatic int unsigned stat_slot_base(input int unsigned s);
        case (s)
            0:       return 13;
            1:       return 15;
            2:       return 17;
            default: return 29;
        endcase
    endfunction

    // Handshake flags held across word cycles.
    typedef struct packed {
        logic pending;   // character latched, not yet sent
        logic rdy_seen;  // ready bit already driven in some word cycle
        logic xmit;      // key code goes out in this word cycle
        logic stat_req;  // static transfer requested this word cycle
        logic coll;      // collision pulse
    } hs_flags_t;

endpackage

// File: rtl/kbd_bit_timer.sv
module kbd_bit_timer #(
    parameter int unsigned CYCLE_LEN = kbd_pkg::WORD_BITS
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cm_i,
    output logic [CYCLE_LEN-1:0] pos_o,
    output logic                 sync_err_o
);

    typedef struct packed {
        logic [CYCLE_LEN-1:0] pos;
        logic                 err;
    } tmr_t;

    tmr_t q, d;
    logic [CYCLE_LEN-1:0] chain;
    logic                 locked;

    // One stage per bit time; the last stage feeds the first (R2).
    for (genvar i = 0; i < CYCLE_LEN; i++) begin : g_stage
        if (i == 0) begin : g_wrap
            assign chain[i] = q.pos[CYCLE_LEN-1];
        end else begin : g_link
            assign chain[i] = q.pos[i-1];
        end
    end

    always_comb begin
        d      = q;
        d.err  = 1'b0;
        locked = |q.pos;
        if (!locked) begin
            // First marker after reset starts the chain at bit 1 next clock.
            if (cm_i) begin
                d.pos    = '0;
                d.pos[1] = 1'b1;
            end
        end else begin
            d.pos = chain;
            // A marker away from bit 0 is ignored and reported (R10).
            d.err = cm_i & ~q.pos[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pos_o      = q.pos;
    assign sync_err_o = q.err;

endmodule

// File: rtl/kbd_xfer_ctl.sv
module kbd_xfer_ctl #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_valid_i,
    input  logic [CODE_W-1:0] key_code_i,
    input  logic              cmd_i,
    input  logic              at_stat_cmd_i,
    input  logic              at_key_cmd_i,
    input  logic              at_ready_i,
    input  logic              code_win_i,
    input  logic              at_last_i,
    output logic              pending_o,
    output logic              stat_req_o,
    output logic              xmit_o,
    output logic              code_bit_o,
    output logic              coll_err_o
);
    import kbd_pkg::*;

    typedef struct packed {
        hs_flags_t         f;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] sh;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d        = q;
        d.f.coll = 1'b0;

        // R4: latch a key only when none is pending.
        if (key_valid_i && !q.f.pending) begin
            d.f.pending = 1'b1;
            d.code      = key_code_i;
        end

        // R8: static request sampled at its command bit.
        if (at_stat_cmd_i) d.f.stat_req = cmd_i;

        // R6 / R9: transmit-key command.
        if (at_key_cmd_i && cmd_i) begin
            if (q.f.stat_req) begin
                d.f.coll     = 1'b1;
                d.f.stat_req = 1'b0;
            end
            if (q.f.rdy_seen) begin
                d.f.xmit = 1'b1;
                d.sh     = q.code;
            end
        end

        // R5: remember that ready went out.
        if (at_ready_i && q.f.pending) d.f.rdy_seen = 1'b1;

        // R7: LSB-first shifting during the code window.
        if (code_win_i && q.f.xmit) d.sh = q.sh >> 1;

        // End of word cycle: close static request, retire sent character.
        if (at_last_i) begin
            d.f.stat_req = 1'b0;
            if (q.f.xmit) begin
                d.f.pending  = 1'b0;
                d.f.rdy_seen = 1'b0;
                d.f.xmit     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pending_o  = q.f.pending;
    assign stat_req_o = q.f.stat_req;
    assign xmit_o     = q.f.xmit;
    assign code_bit_o = q.sh[0];
    assign coll_err_o = q.f.coll;

endmodule

// File: rtl/kbd_bus_mux.sv
module kbd_bus_mux #(
    parameter int unsigned CYCLE_LEN = kbd_pkg::WORD_BITS,
    parameter int unsigned CODE_W    = 8
) (
    input  logic                       [CYCLE_LEN-1:0] pos_i,
    input  kbd_pkg::slot_sel_t                         slot_sel_i,
    input  logic [kbd_pkg::STAT_W-1:0]                 stat_i,
    input  logic                                       stat_req_i,
    input  logic                                       pending_i,
    input  logic                                       xmit_i,
    input  logic                                       code_bit_i,
    output logic                                       bus_o,
    output logic                                       oe_o
);
    import kbd_pkg::*;

    logic [STAT_SLOTS-1:0] slot_oe;
    logic [STAT_SLOTS-1:0] slot_bit;
    logic                  rdy_oe;
    logic                  code_oe;

    // R8: one decoder per static slot.
    for (genvar s = 0; s < STAT_SLOTS; s++) begin : g_slot
        localparam int unsigned BASE = stat_slot_base(s);
        logic [STAT_W-1:0] hit;
        for (genvar w = 0; w < STAT_W; w++) begin : g_bit
            assign hit[w] = pos_i[BASE+w];
        end
        assign slot_oe[s]  = stat_req_i && (slot_sel_i == slot_sel_t'(s)) && (|hit);
        assign slot_bit[s] = slot_oe[s] && (|(hit & stat_i));
    end

    assign rdy_oe  = pending_i && pos_i[T_READY];                      // R5
    assign code_oe = xmit_i && (|pos_i[T_CODE0 +: CODE_W]);            // R7

    assign oe_o  = (|slot_oe) | rdy_oe | code_oe;
    assign bus_o = (|slot_bit) | rdy_oe | (code_oe & code_bit_i);      // R3: 0 when idle

endmodule

// File: rtl/kbd_slot_if.sv
module kbd_slot_if #(
    parameter int unsigned CYCLE_LEN = kbd_pkg::WORD_BITS,
    parameter int unsigned CODE_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cm_i,
    input  logic              cmd_i,
    input  logic              key_valid_i,
    input  logic [CODE_W-1:0] key_code_i,
    input  logic [1:0]        stat_i,
    input  logic [1:0]        slot_sel_i,
    output logic              bus_o,
    output logic              bus_oe_o,
    output logic              sync_err_o,
    output logic              coll_err_o
);
    import kbd_pkg::*;

    logic [CYCLE_LEN-1:0] pos;
    logic                 pending;
    logic                 stat_req;
    logic                 xmit;
    logic                 code_bit;
    logic                 code_win;

    assign code_win = |pos[T_CODE0 +: CODE_W];

    kbd_bit_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cm_i       (cm_i),
        .pos_o      (pos),
        .sync_err_o (sync_err_o)
    );

    kbd_xfer_ctl #(.CODE_W(CODE_W)) u_ctl (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .key_valid_i   (key_valid_i),
        .key_code_i    (key_code_i),
        .cmd_i         (cmd_i),
        .at_stat_cmd_i (pos[T_STAT_CMD]),
        .at_key_cmd_i  (pos[T_KEY_CMD]),
        .at_ready_i    (pos[T_READY]),
        .code_win_i    (code_win),
        .at_last_i     (pos[CYCLE_LEN-1]),
        .pending_o     (pending),
        .stat_req_o    (stat_req),
        .xmit_o        (xmit),
        .code_bit_o    (code_bit),
        .coll_err_o    (coll_err_o)
    );

    kbd_bus_mux #(.CYCLE_LEN(CYCLE_LEN), .CODE_W(CODE_W)) u_mux (
        .pos_i      (pos),
        .slot_sel_i (slot_sel_t'(slot_sel_i)),
        .stat_i     (stat_i),
        .stat_req_i (stat_req),
        .pending_i  (pending),
        .xmit_i     (xmit),
        .code_bit_i (code_bit),
        .bus_o      (bus_o),
        .oe_o       (bus_oe_o)
    );

endmodule

// File: rtl/kbd_slot_if_chk.sv
module kbd_slot_if_chk #(
    parameter int unsigned CYCLE_LEN = kbd_pkg::WORD_BITS
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 cm_i,
    input logic                 bus_o,
    input logic                 bus_oe_o,
    input logic                 sync_err_o,
    input logic                 coll_err_o,
    input logic [CYCLE_LEN-1:0] pos
);
    import kbd_pkg::*;

    logic in_win;
    assign in_win = |pos[WIN_LAST:WIN_FIRST];

    assert_oe_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> (in_win && !pos[T_STAT_CMD] && !pos[T_KEY_CMD]));

    assert_bus_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_oe_o |-> !bus_o);

    assert_stage_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pos));

    assert_stage_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos[CYCLE_LEN-1] |=> pos[0]);

    assert_ready_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_oe_o && pos[T_READY]) |-> bus_o);

    assert_coll_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coll_err_o |-> pos[T_KEY_CMD+1]);

    assert_sync_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_err_o |-> $past(cm_i));

endmodule

bind kbd_slot_if kbd_slot_if_chk #(.CYCLE_LEN(CYCLE_LEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cm_i       (cm_i),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o),
    .sync_err_o (sync_err_o),
    .coll_err_o (coll_err_o),
    .pos        (pos)
);

// File: tb/kbd_slot_if_tb.sv
module kbd_slot_if_tb;
    localparam int CYC = 76;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cm = 1'b0, cmd = 1'b0, kv = 1'b0;
    logic [CW-1:0] kc = '0;
    logic [1:0]    st = '0, ss = '0;
    logic          bus, oe, serr, cerr;

    always #4 clk = ~clk;   // 125 MHz

    kbd_slot_if #(.CYCLE_LEN(CYC), .CODE_W(CW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cm_i(cm), .cmd_i(cmd),
        .key_valid_i(kv), .key_code_i(kc), .stat_i(st), .slot_sel_i(ss),
        .bus_o(bus), .bus_oe_o(oe), .sync_err_o(serr), .coll_err_o(cerr)
    );

    int checks = 0, fails = 0;
    string focus = "";

    // Reference state, built from the requirements.
    bit            m_sync, m_pend, m_rs, m_x, m_sr, m_cerr, m_serr;
    int            m_t;
    logic [CW-1:0] m_code;

    function automatic int slot_base(input int s);
        return (s == 0) ? 13 : (s == 1) ? 15 : (s == 2) ? 17 : 29;
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bit=%0d actual=%b expected=%b", tag, m_t, act, exp);
        end
    endtask

    task automatic exp_out(output logic eo, output logic eb, output string tag);
        eo = 1'b0; eb = 1'b0; tag = "R3";
        if (!m_sync) begin tag = "R1"; return; end
        if (m_sr) begin
            for (int s = 0; s < 4; s++) begin
                int b = slot_base(s);
                if (int'(ss) == s && (m_t == b || m_t == b + 1)) begin
                    eo = 1'b1; eb = st[m_t-b]; tag = "R8";
                end
            end
        end
        if (m_t == 20) begin
            tag = "R5";
            if (m_pend) begin eo = 1'b1; eb = 1'b1; end
        end
        if (m_t >= 21 && m_t <= 28) begin
            tag = "R7";
            if (m_x) begin eo = 1'b1; eb = m_code[m_t-21]; end
        end
        if (focus != "") tag = {focus, " ", tag};
    endtask

    task automatic do_bit(input bit c, input bit cm_v, input bit kv_v, input logic [CW-1:0] kc_v);
        logic eo, eb;
        string tag;
        bit p, rs, x, sr;
        @(negedge clk);
        exp_out(eo, eb, tag);
        chk(tag, {oe, bus}, {eo, eb});
        chk("R10 R9 errors", {serr, cerr}, {m_serr, m_cerr});
        cm = cm_v; cmd = c; kv = kv_v; kc = kc_v;
        // advance the reference to the next bit time
        p = m_pend; rs = m_rs; x = m_x; sr = m_sr;
        m_cerr = 1'b0; m_serr = 1'b0;
        if (kv_v && !p) begin m_pend = 1'b1; m_code = kc_v; end
        if (!m_sync) begin
            if (cm_v) begin m_sync = 1'b1; m_t = 1; end
            return;
        end
        if (m_t == 11) m_sr = c;
        if (m_t == 12 && c) begin
            if (sr) begin m_cerr = 1'b1; m_sr = 1'b0; end
            if (rs) m_x = 1'b1;
        end
        if (m_t == 20 && p) m_rs = 1'b1;
        if (m_t == CYC - 1) begin
            m_sr = 1'b0;
            if (x) begin m_pend = 1'b0; m_rs = 1'b0; m_x = 1'b0; end
        end
        if (cm_v && m_t != 0) m_serr = 1'b1;
        m_t = (m_t + 1) % CYC;
    endtask

    // One full word cycle starting at bit 0.
    task automatic word(input bit c11, input bit c12, input int kbit, input logic [CW-1:0] kcode,
                        input int stray, input logic [1:0] sel, input logic [1:0] sv);
        ss = sel; st = sv;
        for (int b = 0; b < CYC; b++) begin
            do_bit((b == 11) ? c11 : (b == 12) ? c12 : 1'b0,
                   (b == 0) || (b == stray), b == kbit, kcode);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog bit=%0d actual=hung expected=done", m_t);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        m_sync = 0; m_pend = 0; m_rs = 0; m_x = 0; m_sr = 0; m_cerr = 0; m_serr = 0;
        m_t = 0; m_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet before any marker
        for (int i = 0; i < 6; i++) do_bit(1'b1, 1'b0, 1'b0, '0);
        // R2: first marker accepted
        focus = "R2";
        word(0, 0, -1, '0, -1, 2'd0, 2'b00);
        // R6: command in the same cycle as the key arrives is ignored
        focus = "R6";
        word(0, 1, 5, 8'hA5, -1, 2'd0, 2'b00);
        // R7 + R4: send A5, a second key during the send is dropped
        focus = "R4";
        word(0, 1, 30, 8'hB3, -1, 2'd0, 2'b00);
        word(0, 0, -1, '0, -1, 2'd0, 2'b00);
        // R6: key after bit 20 -> ready next cycle -> command before ready ignored
        focus = "R6";
        word(0, 0, 40, 8'h3C, -1, 2'd0, 2'b00);
        word(0, 1, -1, '0, -1, 2'd0, 2'b00);
        word(0, 1, -1, '0, -1, 2'd0, 2'b00);
        // R8: each static slot
        focus = "R8";
        for (int s = 0; s < 4; s++) word(1, 0, -1, '0, -1, 2'(s), 2'(s + 1));
        // R9: collision without and with a ready character
        focus = "R9";
        word(1, 1, -1, '0, -1, 2'd1, 2'b11);
        word(0, 0, 3, 8'h81, -1, 2'd0, 2'b00);
        word(1, 1, -1, '0, -1, 2'd0, 2'b11);
        // R10: stray marker mid-cycle
        focus = "R10";
        word(0, 0, -1, '0, 40, 2'd0, 2'b00);
        word(0, 0, -1, '0, 1, 2'd3, 2'b10);
        focus = "";
        // random traffic
        for (int i = 0; i < 60; i++) begin
            bit c11 = ($urandom % 3) == 0;
            bit c12 = ($urandom % 2) == 0;
            int kb  = (($urandom % 3) == 0) ? int'($urandom % CYC) : -1;
            int sb  = (($urandom % 10) == 0) ? 1 + int'($urandom % (CYC - 1)) : -1;
            word(c11, c12, kb, CW'($urandom), sb, 2'($urandom), 2'($urandom));
        end
        summary();
    end

endmodule